// File: doc/BRIEF.md
# Paged RAM Mapper with Write Protection

This block maps a 64 KB processor address space onto a larger RAM in four 16 KB pages. Each page has its own segment register, loaded by I/O writes to a group of four ports, and the selected segment number is joined to the low fourteen address bits and added to a fixed base to form the RAM address. The block computes that address and the write strobe for each processor access and passes the access on to the RAM. It holds no RAM itself and does no slot selection.

A control register adds two things. It can write-protect any of the four pages, and it can open a small control window inside page 1 or page 2. Through that window the segment registers and the control register can be read and written as memory. An I/O write to the control port can only switch the window on or off. Segment registers can be read back over I/O when a read-enable pin is high.

Processor memory accesses use a valid/ready pair (`mem_valid`/`mem_ready`), and forwarded accesses leave on a second pair (`ram_valid`/`ram_ready`). The block has no buffering. A forwarded access is ready exactly when the RAM is ready. `ram_valid` never waits on `ram_ready`, and the request fields follow the processor's inputs in the same cycle. Window accesses and dropped writes complete in one cycle and are never forwarded. The I/O side is plain strobes.

Top module: `paged_mapper`

## Requirements
- R1: After reset, the segment register of page n holds 3-n (page 0 = 3 ... page 3 = 0), and the control register holds 0.
- R2: An I/O write (`io_wr`) to a port whose bits [7:2] are all ones loads segment register `io_port[1:0]` with `io_wdata[5:0]`. Bits 7:6 are discarded.
- R3: A forwarded access drives `ram_addr` = (BASE_ADDR + segment[mem_addr[15:14]] * 0x4000 + mem_addr[13:0]) modulo 2^RAM_AW. The defaults are BASE_ADDR 0x80000 and RAM_AW 21. `ram_we` equals `mem_write`, and `ram_wdata` equals `mem_wdata`.
- R4: Control bit n (n = 0..3) protects page n. A write to a protected page gives `ram_valid` low and `mem_ready` high, so the write completes and is dropped. Reads of a protected page are forwarded.
- R5: Control bit 7 opens the window. The window lies in page 1 when control bit 3 is 1 and in page 2 otherwise. Only the in-page offsets 0x3C and 0xFC..0xFF (address bits [7:0], with any bits [13:8]) belong to it. All other addresses are forwarded.
- R6: A window access raises `mem_win` and `mem_ready` and keeps `ram_valid` low. A read at offset 0xFC..0xFF returns `{2'b00, segment[offset[1:0]]}` on `mem_rdata`, and a read at 0x3C returns the control register. At all other times `mem_rdata` is 0xFF.
- R7: A window write at 0xFC..0xFF loads that segment register with `mem_wdata[5:0]`. A window write at 0x3C loads control bits 6:0 from `mem_wdata[6:0]` and control bit 7 from `mem_wdata[1]`. Window writes ignore page protection.
- R8: An I/O write to port 0x3C while `io_ctl_en` is high sets control bit 7 to `io_wdata[7]` and leaves bits 6:0 unchanged. While `io_ctl_en` is low, the write has no effect.
- R9: `io_rdata` is `{2'b00, segment[io_port[1:0]]}` when `io_rd` and `io_rd_en` are both high and the port is 0xFC..0xFF. Otherwise it is 0xFF.
- R10: For a forwarded access, `mem_ready` equals `ram_ready`.
- R11: When an I/O write and a window write target the same register in the same cycle, the window write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_port | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| io_rd_en | input | 1 | Allows segment readback over I/O |
| io_ctl_en | input | 1 | Allows I/O writes to the control port |
| mem_valid | input | 1 | Processor memory access valid |
| mem_ready | output | 1 | Processor memory access accepted |
| mem_write | input | 1 | Access is a write |
| mem_addr | input | 16 | Processor address |
| mem_wdata | input | 8 | Processor write data |
| mem_rdata | output | 8 | Window read data (0xFF otherwise) |
| mem_win | output | 1 | Access is served by the control window |
| ram_valid | output | 1 | Forwarded RAM request valid |
| ram_ready | input | 1 | RAM accepts request |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAM_AW | RAM byte address |
| ram_wdata | output | 8 | RAM write data |

## Verification
Reads spread over all four pages, after segment loads with distinct values and overflowing upper bits, show whether the page index, the masking and the base offset are each correct. Writes with the protection bits set one at a time separate a dropped write from a forwarded one. A write to the same page with a bit cleared shows that the register index is not shifted. The window is opened in page 2 and then moved to page 1 by a window write whose bit 1 differs from bit 7. Window offsets, near-miss offsets and the other page are all probed, which separates the location decode from the offset decode. I/O writes to the control port with the enable low and then high, back-pressure from the RAM side, and a same-cycle collision between an I/O write and a window write cover the remaining orderings.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int PAGES      = 4;
  localparam int PAGE_BITS  = 14;
  localparam int IDX_W      = $clog2(PAGES);
  localparam int CTRL_W     = 8;
  localparam int WIN_EN_BIT = 7;
  localparam int WIN_LO_BIT = 3;
  localparam int WIN_CP_BIT = 1;
  localparam logic [7:0] CTRL_OFF  = 8'h3C;
  localparam logic [7:0] CTRL_PORT = 8'h3C;
  localparam logic [5:0] SEG_PORT_HI = 6'h3F;

  typedef logic [IDX_W-1:0]  page_t;
  typedef logic [CTRL_W-1:0] ctrl_t;
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
#(
  parameter int SEG_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   io_seg_we,
  input  page_t                  io_idx,
  input  logic [7:0]             io_wdata,
  input  logic                   io_ctl_we,
  input  logic                   win_seg_we,
  input  logic                   win_ctl_we,
  input  page_t                  win_idx,
  input  logic [7:0]             win_wdata,
  output logic [PAGES*SEG_W-1:0] seg_flat,
  output ctrl_t                  ctrl
);
  ctrl_t ctrl_q;

  for (genvar p = 0; p < PAGES; p++) begin : g_seg
    logic [SEG_W-1:0] seg_q;
    localparam logic [SEG_W-1:0] RST_VAL = SEG_W'(PAGES - 1 - p);
    always_ff @(posedge clk) begin
      if (!rst_n) seg_q <= RST_VAL;
      else if (win_seg_we && win_idx == page_t'(p)) seg_q <= win_wdata[SEG_W-1:0];
      else if (io_seg_we && io_idx == page_t'(p)) seg_q <= io_wdata[SEG_W-1:0];
    end
    assign seg_flat[p*SEG_W +: SEG_W] = seg_q;

    // R2
    io_seg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_seg_we && io_idx == page_t'(p) && !(win_seg_we && win_idx == page_t'(p)))
        |=> seg_q == $past(io_wdata[SEG_W-1:0]));
    // R7
    win_seg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_seg_we && win_idx == page_t'(p)) |=> seg_q == $past(win_wdata[SEG_W-1:0]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (win_ctl_we) begin
      ctrl_q <= win_wdata;
      ctrl_q[WIN_EN_BIT] <= win_wdata[WIN_CP_BIT];
    end else if (io_ctl_we) ctrl_q[WIN_EN_BIT] <= io_wdata[WIN_EN_BIT];
  end
  assign ctrl = ctrl_q;

  // R8
  io_ctl_keep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_ctl_we && !win_ctl_we) |=> ctrl_q[WIN_EN_BIT-1:0] == $past(ctrl_q[WIN_EN_BIT-1:0]));
  // R7
  win_ctl_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_ctl_we |=> ctrl_q[WIN_EN_BIT] == $past(win_wdata[WIN_CP_BIT]));
endmodule

// File: rtl/mapper_decode.sv
module mapper_decode
  import mapper_pkg::*;
(
  input  ctrl_t       ctrl,
  input  logic        mem_valid,
  input  logic        mem_write,
  input  logic [15:0] mem_addr,
  output page_t       page,
  output logic        win_hit,
  output logic        win_is_ctl,
  output page_t       win_idx,
  output logic        prot_drop
);
  page_t win_page;
  logic  off_seg, off_ctl;

  assign page     = mem_addr[15:14];
  assign win_page = ctrl[WIN_LO_BIT] ? page_t'(1) : page_t'(2);
  assign off_seg  = mem_addr[7:2] == SEG_PORT_HI;
  assign off_ctl  = mem_addr[7:0] == CTRL_OFF;

  always_comb begin
    win_hit = mem_valid && ctrl[WIN_EN_BIT] && (page == win_page) && (off_seg || off_ctl);
    win_is_ctl = off_ctl;
    win_idx = mem_addr[1:0];
    prot_drop = mem_valid && mem_write && !win_hit && ctrl[page];
  end
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
  import mapper_pkg::*;
#(
  parameter int SEG_W = 6,
  parameter int RAM_AW = 21,
  parameter logic [RAM_AW-1:0] BASE_ADDR = 'h80000
) (
  input  logic [PAGES*SEG_W-1:0] seg_flat,
  input  logic [15:0]            mem_addr,
  output logic [RAM_AW-1:0]      ram_addr
);
  localparam int LIN_W = SEG_W + PAGE_BITS;
  logic [SEG_W-1:0] seg_sel;
  logic [LIN_W-1:0] lin;

  always_comb begin
    seg_sel = seg_flat[mem_addr[15:14]*SEG_W +: SEG_W];
    lin = {seg_sel, mem_addr[PAGE_BITS-1:0]};
    ram_addr = RAM_AW'(lin) + BASE_ADDR;
  end
endmodule

// File: rtl/paged_mapper.sv
module paged_mapper
  import mapper_pkg::*;
#(
  parameter int SEG_W = 6,
  parameter int RAM_AW = 21,
  parameter logic [RAM_AW-1:0] BASE_ADDR = 'h80000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_port,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              io_rd_en,
  input  logic              io_ctl_en,
  input  logic              mem_valid,
  output logic              mem_ready,
  input  logic              mem_write,
  input  logic [15:0]       mem_addr,
  input  logic [7:0]        mem_wdata,
  output logic [7:0]        mem_rdata,
  output logic              mem_win,
  output logic              ram_valid,
  input  logic              ram_ready,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);
  logic [PAGES*SEG_W-1:0] seg_flat;
  ctrl_t ctrl;
  page_t page, win_idx;
  logic  win_hit, win_is_ctl, prot_drop;
  logic  io_seg_hit, io_seg_we, io_ctl_we, win_seg_we, win_ctl_we;
  logic [SEG_W-1:0] io_seg_sel, win_seg_sel;

  assign io_seg_hit = io_port[7:2] == SEG_PORT_HI;
  assign io_seg_we  = io_wr && io_seg_hit;
  assign io_ctl_we  = io_wr && io_ctl_en && (io_port == CTRL_PORT);
  assign win_seg_we = win_hit && mem_write && !win_is_ctl;
  assign win_ctl_we = win_hit && mem_write && win_is_ctl;

  mapper_decode u_dec (
    .ctrl(ctrl), .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .page(page), .win_hit(win_hit), .win_is_ctl(win_is_ctl), .win_idx(win_idx),
    .prot_drop(prot_drop)
  );

  mapper_regs #(.SEG_W(SEG_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .io_seg_we(io_seg_we), .io_idx(io_port[1:0]), .io_wdata(io_wdata),
    .io_ctl_we(io_ctl_we), .win_seg_we(win_seg_we), .win_ctl_we(win_ctl_we),
    .win_idx(win_idx), .win_wdata(mem_wdata), .seg_flat(seg_flat), .ctrl(ctrl)
  );

  mapper_xlate #(.SEG_W(SEG_W), .RAM_AW(RAM_AW), .BASE_ADDR(BASE_ADDR)) u_xl (
    .seg_flat(seg_flat), .mem_addr(mem_addr), .ram_addr(ram_addr)
  );

  always_comb begin
    io_seg_sel  = seg_flat[io_port[1:0]*SEG_W +: SEG_W];
    win_seg_sel = seg_flat[win_idx*SEG_W +: SEG_W];
    io_rdata  = (io_rd && io_rd_en && io_seg_hit) ? 8'(io_seg_sel) : 8'hFF;
    mem_win   = win_hit;
    ram_valid = mem_valid && !win_hit && !prot_drop;
    ram_we    = mem_write;
    ram_wdata = mem_wdata;
    mem_ready = win_hit || prot_drop || ram_ready;
    mem_rdata = 8'hFF;
    if (win_hit && !mem_write) mem_rdata = win_is_ctl ? ctrl : 8'(win_seg_sel);
  end

  // R4
  prot_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && ctrl[page] && !mem_win) |-> (!ram_valid && mem_ready));
  // R6
  win_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_win |-> (!ram_valid && mem_ready));
  // R10
  ready_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_valid |-> (mem_ready == ram_ready));
  // R3
  addr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_valid |-> (ram_addr[PAGE_BITS-1:0] == mem_addr[PAGE_BITS-1:0]));
endmodule

// File: tb/sim_paged_mapper.sv
`timescale 1ns/1ps
module sim_paged_mapper;
  logic clk = 0, rst_n = 0;
  logic io_wr = 0, io_rd = 0, io_rd_en = 0, io_ctl_en = 0;
  logic [7:0] io_port = 0, io_wdata = 0, io_rdata, mem_wdata = 0, mem_rdata, ram_wdata;
  logic mem_valid = 0, mem_ready, mem_write = 0, mem_win, ram_valid, ram_ready = 1, ram_we;
  logic [15:0] mem_addr = 0;
  logic [20:0] ram_addr;
  int checks = 0, errors = 0;
  bit done = 0;
  int seg_m[4];
  int ctrl_m;

  always #2.5 clk = ~clk;

  paged_mapper u0 (.*);

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit win_m();
    int pg = mem_addr[15:14];
    int wp = ctrl_m[3] ? 1 : 2;
    return mem_valid && ctrl_m[7] && pg == wp &&
           (mem_addr[7:0] >= 8'hFC || mem_addr[7:0] == 8'h3C);
  endfunction

  task automatic step();
    bit w; bit drop; int pg; int ea;
    #1;
    pg = mem_addr[15:14];
    w = win_m();
    drop = mem_valid && mem_write && !w && ctrl_m[pg];
    chk("R6 mem_win", mem_win, w);
    chk("R4 ram_valid", ram_valid, mem_valid && !w && !drop);
    chk("R10 mem_ready", mem_ready, w || drop || ram_ready);
    if (mem_valid && !w && !drop) begin
      ea = (seg_m[pg] * 16384 + (mem_addr & 16'h3FFF) + 'h80000) % (1 << 21);
      chk("R3 ram_addr", ram_addr, ea);
      chk("R3 ram_we", ram_we, mem_write);
    end
    if (w && !mem_write)
      chk("R6 mem_rdata", mem_rdata, mem_addr[7:0] == 8'h3C ? ctrl_m : seg_m[mem_addr[1:0]]);
    else chk("R6 mem_rdata idle", mem_rdata, 8'hFF);
    chk("R9 io_rdata", io_rdata,
        (io_rd && io_rd_en && io_port >= 8'hFC) ? seg_m[io_port[1:0]] : 8'hFF);
    @(posedge clk);
    if (io_wr && io_port >= 8'hFC) seg_m[io_port[1:0]] = io_wdata & 8'h3F;
    if (io_wr && io_port == 8'h3C && io_ctl_en) ctrl_m = (ctrl_m & 8'h7F) | (io_wdata & 8'h80);
    if (w && mem_write) begin
      if (mem_addr[7:0] == 8'h3C) ctrl_m = (mem_wdata & 8'h7F) | (mem_wdata[1] ? 8'h80 : 0);
      else seg_m[mem_addr[1:0]] = mem_wdata & 8'h3F;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    io_wr = 0; io_rd = 0; mem_valid = 0; mem_write = 0;
  endtask

  task automatic iow(int port, int d);
    idle(); io_wr = 1; io_port = port[7:0]; io_wdata = d[7:0]; step(); idle();
  endtask

  task automatic ior(int port);
    idle(); io_rd = 1; io_port = port[7:0]; step(); idle();
  endtask

  task automatic mrd(int a);
    idle(); mem_valid = 1; mem_addr = a[15:0]; step(); idle();
  endtask

  task automatic mwr(int a, int d);
    idle(); mem_valid = 1; mem_write = 1; mem_addr = a[15:0]; mem_wdata = d[7:0]; step(); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    seg_m = '{3, 2, 1, 0}; ctrl_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values read back through I/O with readback enabled
    io_rd_en = 1;
    for (int p = 0; p < 4; p++) begin
      idle(); io_rd = 1; io_port = 8'hFC + p[7:0]; #1;
      chk("R1 seg reset", io_rdata, 3 - p);
      step(); idle();
    end
    mrd(16'h0123); mrd(16'hC456);
    // R9 readback disabled returns FF
    io_rd_en = 0; ior(8'hFD); io_rd_en = 1; ior(8'h3C);
    // R2 segment loads with overflowing upper bits
    iow(8'hFC, 8'hC5); iow(8'hFD, 8'h2A); iow(8'hFE, 8'h7F); iow(8'hFF, 8'h10);
    for (int p = 0; p < 4; p++) ior(8'hFC + p);
    // R3 address formation in every page
    mrd(16'h0000); mrd(16'h7FFF); mrd(16'h9ABC); mrd(16'hFFFF); mwr(16'h4001, 8'h55);
    // R8 control port write ignored when disabled
    io_ctl_en = 0; iow(8'h3C, 8'hFF); mrd(16'h80FC); mwr(16'h8000, 8'h11);
    // R8 enabled: only bit 7, window opens in page 2
    io_ctl_en = 1; iow(8'h3C, 8'h8F);
    // R5 window decode in page 2
    mrd(16'h80FC); mrd(16'hBFFE); mrd(16'h803C); mrd(16'h80FB); mrd(16'h403C); mrd(16'h803D);
    // R7 window segment write, protection does not apply
    mwr(16'h80FE, 8'hE3); ior(8'hFE); mrd(16'hA5FE);
    // R7 control via window: bit1 copied into bit7, protect pages 1 and 3, window to page 1
    mwr(16'h803C, 8'h0A); mrd(16'h403C); mrd(16'h80FC); mrd(16'h40FF);
    // R4 protected writes dropped, reads forwarded, unprotected writes pass
    mwr(16'h4100, 8'h01); mwr(16'hC100, 8'h02); mrd(16'hC100);
    mwr(16'h0100, 8'h03); mwr(16'h8100, 8'h04);
    // R10 back-pressure
    ram_ready = 0; mrd(16'h0200); mwr(16'h4200, 8'h05); mrd(16'h40FD); ram_ready = 1;
    // R11 same-cycle collision: window write wins over I/O write
    idle(); io_wr = 1; io_port = 8'hFD; io_wdata = 8'h01;
    mem_valid = 1; mem_write = 1; mem_addr = 16'h40FD; mem_wdata = 8'h22; step(); idle();
    ior(8'hFD); mrd(16'h40FD);
    // R8 io write turns window off, bits 6:0 kept
    iow(8'h3C, 8'h00); mrd(16'h40FD); mwr(16'h4000, 8'h06);
    iow(8'h3C, 8'h80); mrd(16'h403C);
    // R1 reset again restores defaults
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
    seg_m = '{3, 2, 1, 0}; ctrl_m = 0;
    for (int p = 0; p < 4; p++) ior(8'hFC + p);
    mwr(16'h4000, 8'h07); mrd(16'h40FC);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule